// File: doc/BRIEF.md
# Serial-Clock-Paced SAR Conversion Sequencer

This block runs one successive-approximation conversion frame that takes its pace entirely from the serial clock. A command receiver pulses `start` once it has seen the start bit of a command word. With that pulse it presents two settings: the acquisition length (short or long) and the output coding (unipolar or bipolar). From that point the sequencer counts serial-clock falling edges. It ends acquisition by raising the sample/hold control and raises a strobe one edge later. It then resolves 14 bits against an external comparator, one bit per falling edge, and presents each resolved bit on the serial data output while the conversion is still running.

Every input is assumed to be synchronous to `clk` already. The serial clock is oversampled, and a falling edge is counted only while chip select is low. Releasing chip select in the middle of a frame therefore freezes all progress, so the frame can be moved as separate bytes. The strobe and the data output carry enables that model the high-impedance state. Those enables are active only during a frame and only while chip select is low.

Top module: `ext_sar_seq`

## Requirements
- R1: After reset `hold`, `strobe`, `strobe_oe`, `dout`, `dout_oe` are 0 and `dac_code` is 0.
- R2: In short acquisition (`long_acq`=0), counting falling edges from 1 after `start`: `hold` rises at edge 6. `strobe` is 1 after edge 7 and returns to 0 at edge 8, so it is high for exactly one counted period.
- R3: In long acquisition (`long_acq`=1), `hold` rises at edge 14, `strobe` is 1 only between edges 15 and 16, and the MSB appears on `dout` at edge 16.
- R4: `dout` carries result bits B13 down to B0 on edges 8..21 (short) or 16..29 (long) and is 0 on the remaining edges. The frame ends at edge 24 (short) or 32 (long), after which `dout_oe` and `strobe_oe` are 0. `hold` is 1 from the hold edge through the B0 edge and 0 after it.
- R5: Each step sets the next trial bit on `dac_code`, starting with bit 13 at the strobe edge. The step keeps the bit when `cmp_ge`=1 (input at or above the trial level). After the B0 edge `dac_code` equals the offset-binary input value.
- R6: With `unipolar`=1 the serial word equals `dac_code`, which is straight binary. With `unipolar`=0 the MSB of the serial word is inverted, which gives two's complement.
- R7: While `cs_n`=1, `dout_oe` and `strobe_oe` are 0, serial-clock falling edges are not counted, and `strobe` holds its value. When `cs_n` returns to 0, the frame resumes and produces the same bits at the same counted edges.
- R8: An `abort` pulse returns the sequencer to idle in the next cycle. `strobe`, `hold`, `dout_oe` and `strobe_oe` become 0 and later edges produce no output until a new `start`.
- R9: A `start` during a frame restarts the count from zero with the newly presented settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| start | input | 1 | One-cycle pulse: start bit received, begin a frame |
| long_acq | input | 1 | 1 selects long acquisition, sampled with start |
| unipolar | input | 1 | 1 selects straight binary, 0 selects two's complement, sampled with start |
| abort | input | 1 | One-cycle pulse: drop the current frame |
| cmp_ge | input | 1 | Comparator: 1 when the held input is at or above dac_code |
| hold | output | 1 | Sample/hold control, 1 holds |
| dac_code | output | 14 | Trial code for the capacitive DAC |
| strobe | output | 1 | Pulse marking the end of acquisition |
| strobe_oe | output | 1 | Output enable for strobe |
| dout | output | 1 | Serial result, MSB first |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The hardest situation to reach is a chip-select release that lands exactly while the strobe is high. The bench must show that edges arriving with chip select high are ignored and that the strobe stays up until the next counted edge. The frame task can raise chip select right after the strobe edge and issue two serial-clock falls during the gap. It then lowers chip select and checks that the remaining bits still arrive at the original edge numbers. Aborts and restarts are driven ten edges into a frame, so that the sequencer is in the middle of a conversion when they arrive.

// File: rtl/ext_sar_seq.sv
module ext_sar_seq #(
  parameter int NBITS       = 14,
  parameter int SHORT_FRAME = 24,
  parameter int LONG_FRAME  = 32,
  parameter int SHORT_HOLD  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             start,
  input  logic             long_acq,
  input  logic             unipolar,
  input  logic             abort,
  input  logic             cmp_ge,
  output logic             hold,
  output logic [NBITS-1:0] dac_code,
  output logic             strobe,
  output logic             strobe_oe,
  output logic             dout,
  output logic             dout_oe
);
  localparam int EXTRA = LONG_FRAME - SHORT_FRAME;
  localparam int CW    = $clog2(LONG_FRAME + 1);

  logic             busy, sclk_q, long_q, uni_q, dout_r;
  logic [CW-1:0]    cnt;
  logic [NBITS-1:0] mask;

  wire            fall  = busy & ~cs_n & sclk_q & ~sclk;
  wire [CW-1:0]   nxt   = cnt + 1'b1;
  wire [CW-1:0]   e_hld = long_q ? CW'(SHORT_HOLD + EXTRA) : CW'(SHORT_HOLD);
  wire [CW-1:0]   e_stb = e_hld + 1'b1;
  wire [CW-1:0]   e_msb = e_hld + CW'(2);
  wire [CW-1:0]   e_lsb = e_msb + CW'(NBITS - 1);
  wire [CW-1:0]   e_end = long_q ? CW'(LONG_FRAME) : CW'(SHORT_FRAME);
  wire            step  = (nxt >= e_msb) && (nxt <= e_lsb);
  wire [NBITS-1:0] kept = cmp_ge ? dac_code : (dac_code & ~mask);

  assign dout      = dout_r;
  assign dout_oe   = busy & ~cs_n;
  assign strobe_oe = busy & ~cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk_q <= 1'b0; long_q <= 1'b0; uni_q <= 1'b0;
      cnt <= '0; hold <= 1'b0; strobe <= 1'b0; dout_r <= 1'b0;
      dac_code <= '0; mask <= '0;
    end else begin
      sclk_q <= sclk;
      if (abort || start) begin
        busy <= start & ~abort;
        long_q <= long_acq; uni_q <= unipolar;
        cnt <= '0; hold <= 1'b0; strobe <= 1'b0; dout_r <= 1'b0;
        dac_code <= '0; mask <= '0;
      end else if (fall) begin
        cnt    <= nxt;
        strobe <= (nxt == e_stb);
        if (nxt == e_hld) hold <= 1'b1;
        if (nxt == e_lsb + 1'b1) hold <= 1'b0;
        if (nxt == e_stb) begin
          dac_code <= NBITS'(1) << (NBITS - 1);
          mask     <= NBITS'(1) << (NBITS - 1);
        end
        if (step) begin
          dac_code <= kept | (mask >> 1);
          mask     <= mask >> 1;
          dout_r   <= cmp_ge ^ (~uni_q & mask[NBITS-1]);
        end else begin
          dout_r <= 1'b0;
        end
        if (nxt == e_end) begin
          busy <= 1'b0; cnt <= '0; hold <= 1'b0;
        end
      end
    end
  end

  // R2
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(fall));
  // R2
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && fall && !start && !abort) |=> !strobe);
  // R4
  strobe_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> hold);
  // R5
  trial_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask));
  // R7
  cs_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_n && !start && !abort) |=> ($stable(dac_code) && $stable(cnt) && $stable(strobe)));
  // R7
  oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe || strobe_oe) |-> !cs_n);
  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!strobe && !hold && !dout_oe && !strobe_oe));
endmodule

// File: tb/sim_ext_sar_seq.sv
module sim_ext_sar_seq;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, start = 0, long_acq = 0;
  logic unipolar = 0, abort = 0;
  logic [13:0] vin = '0;
  logic hold, strobe, strobe_oe, dout, dout_oe;
  logic [13:0] dac_code;
  wire cmp_ge = (vin >= dac_code);
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ext_sar_seq u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .start(start),
    .long_acq(long_acq), .unipolar(unipolar), .abort(abort), .cmp_ge(cmp_ge),
    .hold(hold), .dac_code(dac_code), .strobe(strobe), .strobe_oe(strobe_oe),
    .dout(dout), .dout_oe(dout_oe));

  localparam logic [15:0] VEC [6] = '{16'h5555, 16'hAAAA, 16'hC000,
                                      16'h3FFF, 16'hA000, 16'h4001};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fedge();
    @(negedge clk) sclk = 1;
    repeat (3) @(negedge clk);
    sclk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic go(input logic [13:0] v, input logic lg, input logic un);
    vin = v; long_acq = lg; unipolar = un; cs_n = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic frame(input logic [13:0] v, input logic lg, input logic un, input bit split);
    logic [13:0] w;
    int eh, es, em, el, ee;
    string tg;
    w  = un ? v : {~v[13], v[12:0]};
    eh = lg ? 14 : 6; es = eh + 1; em = eh + 2; el = em + 13; ee = lg ? 32 : 24;
    tg = lg ? "R3" : "R2";
    go(v, lg, un);
    for (int k = 1; k <= ee; k++) begin
      fedge();
      chk(strobe == (k == es), tg, strobe, k == es);
      chk(hold == (k >= eh && k <= el), "R4 hold", hold, k >= eh && k <= el);
      chk(dout == ((k >= em && k <= el) ? w[13 - (k - em)] : 1'b0),
          un ? "R4 R6 uni" : "R4 R6 bip", dout,
          (k >= em && k <= el) ? w[13 - (k - em)] : 1'b0);
      chk(dout_oe == (k < ee) && strobe_oe == (k < ee), "R4 oe", dout_oe, k < ee);
      if (k == el) chk(dac_code == v, "R5", dac_code, v);
      if (split && k == es) begin
        @(negedge clk) cs_n = 1;
        @(negedge clk);
        chk(!dout_oe && !strobe_oe, "R7 hiz", {dout_oe, strobe_oe}, 0);
        fedge(); fedge();
        cs_n = 0;
        repeat (2) @(negedge clk);
        chk(strobe == 1'b1, "R7 frozen", strobe, 1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!hold && !strobe && !strobe_oe && !dout && !dout_oe && dac_code == 0,
        "R1", {hold, strobe, strobe_oe, dout, dout_oe}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!dout_oe && dac_code == 0, "R1 idle", dac_code, 0);

    foreach (VEC[i]) frame(VEC[i][13:0], VEC[i][15], VEC[i][14], 1'b0);

    frame(14'h1234, 1'b0, 1'b0, 1'b1);
    frame(14'h2F0F, 1'b1, 1'b1, 1'b1);

    // R8 abort mid-conversion
    go(14'h0ABC, 1'b0, 1'b1);
    for (int k = 1; k <= 10; k++) fedge();
    @(negedge clk) abort = 1;
    @(negedge clk) abort = 0;
    chk(!strobe && !hold && !dout_oe && !strobe_oe, "R8",
        {strobe, hold, dout_oe, strobe_oe}, 0);
    for (int k = 0; k < 6; k++) begin
      fedge();
      chk(!dout_oe && !strobe && !hold, "R8 idle", {dout_oe, strobe, hold}, 0);
    end
    frame(14'h0ABC, 1'b0, 1'b1, 1'b0);

    // R9 restart mid-frame with new settings
    go(14'h3333, 1'b0, 1'b0);
    for (int k = 1; k <= 10; k++) fedge();
    frame(14'h0F0F, 1'b1, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule